// File: doc/BRIEF.md
# Bus Interrupt Aggregator and Router

This block collects the seven active-low request levels of a backplane bus and three auxiliary fault sources (bus error, system failure and an abort pushbutton). It folds them onto one maskable host interrupt line, `irq_out`, or onto a non-maskable output, `nmi_out`. Backplane levels are level-sensitive. They pass through two-flop synchronizers and always go to the maskable line. The auxiliary sources are synchronized and edge-captured into sticky event flags. A single select bit sends all three of them to exactly one of the two outputs.

Software programs the block through a byte-wide I/O register port. That port holds a global backplane mask, per-level enables together with the routing select, and per-source auxiliary enables. The same port exposes a live pending port and an event status register. An auxiliary event is cleared by writing its enable bit to 0 and is re-armed by writing the bit back to 1. Acknowledge cycles and vector fetching happen elsewhere.

Register map (8-bit address): `0x30` global mask (bit 7), `0x3D` routing select (bit 0) and level enables (bit n for level n), `0x3E` auxiliary enables, `0x32` pending port (read only), `0x34` event status (read only). Auxiliary bit order everywhere: bit 0 bus error, bit 1 system failure, bit 2 abort.

Top module: `bus_irq_router`

## Requirements
- R1: After reset, address 0x30 reads 0x80 (backplane globally masked), 0x3D, 0x3E, 0x32 and 0x34 read 0x00, and both `irq_out` and `nmi_out` are low.
- R2: Address 0x32 shows backplane level n as bit n, set while `bus_irq_n[n]` is low, independent of any enable; bit 0 always reads 0.
- R3: With bit 7 of 0x30 clear, `irq_out` is high exactly when some level n is requesting and bit n of 0x3D is 1; a requesting level with its enable at 0 has no effect on `irq_out`.
- R4: While bit 7 of 0x30 is 1, no backplane level can raise `irq_out`, whatever the level enables.
- R5: Backplane levels never drive `nmi_out`, whatever the routing select.
- R6: With its enable bit in 0x3E set to 1, a low-to-high transition on an auxiliary source sets its flag in 0x34. The flag stays set after the source falls again.
- R7: Writing a source's enable bit to 0 clears its flag. While that bit stays 0, the flag remains clear and further transitions are not recorded. Writing the bit back to 1 re-arms capture of the next transition.
- R8: Bit 0 of 0x3D routes the OR of the auxiliary flags: 0 sends it to `irq_out`, 1 sends it to `nmi_out`; the flags never drive both outputs.
- R9: A source that is already high when its enable is written to 1 is not recorded until it falls and rises again.
- R10: If a write that clears a source's enable lands in the same clock cycle as that source's captured transition, the flag reads 0 in the following cycle and no output is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_irq_n | input | 7 | Backplane request levels 1..7, active low, asynchronous |
| aux_req | input | 3 | Auxiliary sources, active high: bit 0 bus error, bit 1 system failure, bit 2 abort |
| io_addr | input | 8 | Register address |
| io_wr | input | 1 | Write strobe, one clock per write |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr`, combinational |
| irq_out | output | 1 | Maskable host interrupt |
| nmi_out | output | 1 | Non-maskable interrupt |

## Verification
Two functions can act on an auxiliary flag in the same clock edge: capture of a synchronized rising edge and a register write that drops the source's enable. The bench raises a source, counts the two synchronizer stages and the edge-detect register, and places the clearing write on exactly the edge where the captured transition would set the flag. The flag must read 0 on the following cycle and both outputs must stay low. Separately, exhaustive sweeps of all 128 level patterns against several enable, mask and routing settings are judged against an OR computed in the bench.

// File: rtl/irqr_pkg.sv
`timescale 1ns/1ps
package irqr_pkg;
  localparam int DATA_W = 8;
  localparam int LEVELS = 7;
  localparam int AUX_N  = 3;

  typedef struct packed {
    logic              gmask;
    logic              route_nmi;
    logic [LEVELS:1]   lvl_en;
    logic [AUX_N-1:0]  aux_en;
  } ctrl_t;

  // Backplane contribution to the maskable line.
  function automatic logic any_level(input logic [LEVELS:1] req,
                                     input logic [LEVELS:1] en,
                                     input logic            gmask);
    return (|(req & en)) & ~gmask;
  endfunction

  // Place level n at bit n of a data byte, bit 0 zero.
  function automatic logic [DATA_W-1:0] place_levels(input logic [LEVELS:1] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[LEVELS:1] = v;
    return r;
  endfunction

  // Zero-extend the auxiliary vector to a data byte.
  function automatic logic [DATA_W-1:0] place_aux(input logic [AUX_N-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[AUX_N-1:0] = v;
    return r;
  endfunction
endpackage

// File: rtl/irqr_sync.sv
`timescale 1ns/1ps
module irqr_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/irqr_regs.sv
`timescale 1ns/1ps
module irqr_regs
  import irqr_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] A_MASK  = 8'h30,
  parameter logic [ADDR_W-1:0] A_ROUTE = 8'h3D,
  parameter logic [ADDR_W-1:0] A_AUXEN = 8'h3E,
  parameter logic [ADDR_W-1:0] A_PEND  = 8'h32,
  parameter logic [ADDR_W-1:0] A_STAT  = 8'h34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic [LEVELS:1]   pend,
  input  logic [AUX_N-1:0]  flags,
  output ctrl_t             ctrl,
  output logic [AUX_N-1:0]  aux_clr
);
  logic             gmask_q;
  logic             route_q;
  logic [LEVELS:1]  lvl_en_q;
  logic [AUX_N-1:0] aux_en_q;

  logic wr_mask, wr_route, wr_aux;
  assign wr_mask  = io_wr && (io_addr == A_MASK);
  assign wr_route = io_wr && (io_addr == A_ROUTE);
  assign wr_aux   = io_wr && (io_addr == A_AUXEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gmask_q  <= 1'b1;
      route_q  <= 1'b0;
      lvl_en_q <= '0;
      aux_en_q <= '0;
    end else begin
      if (wr_mask)  gmask_q <= io_wdata[DATA_W-1];
      if (wr_route) begin
        route_q  <= io_wdata[0];
        lvl_en_q <= io_wdata[LEVELS:1];
      end
      if (wr_aux)   aux_en_q <= io_wdata[AUX_N-1:0];
    end
  end

  // Clear strobe: a write that drops an enable bit acts in the same edge.
  assign aux_clr = {AUX_N{wr_aux}} & ~io_wdata[AUX_N-1:0];

  assign ctrl.gmask     = gmask_q;
  assign ctrl.route_nmi = route_q;
  assign ctrl.lvl_en    = lvl_en_q;
  assign ctrl.aux_en    = aux_en_q;

  always_comb begin
    io_rdata = '0;
    if (io_addr == A_MASK)       io_rdata[DATA_W-1] = gmask_q;
    else if (io_addr == A_ROUTE) io_rdata = place_levels(lvl_en_q) | {{(DATA_W-1){1'b0}}, route_q};
    else if (io_addr == A_AUXEN) io_rdata = place_aux(aux_en_q);
    else if (io_addr == A_PEND)  io_rdata = place_levels(pend);
    else if (io_addr == A_STAT)  io_rdata = place_aux(flags);
  end

  AST_ROUTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_route |=> (ctrl.route_nmi == $past(io_wdata[0]))); // R8
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (ctrl.gmask == $past(io_wdata[DATA_W-1]))); // R4
endmodule

// File: rtl/irqr_aux_latch.sv
`timescale 1ns/1ps
module irqr_aux_latch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rise;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src;
  end

  assign rise = src & ~prev_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic flag_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                flag_q <= 1'b0;
      else if (!en[i] || clr[i]) flag_q <= 1'b0;
      else if (rise[i])          flag_q <= 1'b1;
    end
    assign flag[i] = flag_q;

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[i] && en[i] && !clr[i]) |=> flag[i]); // R6
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && en[i] && !clr[i]) |=> flag[i]); // R6
    AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !en[i] |=> !flag[i]); // R7
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] |=> !flag[i]); // R10
    AST_NO_LEVEL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag[i] && !rise[i]) |=> !flag[i]); // R9
  end
endmodule

// File: rtl/bus_irq_router.sv
`timescale 1ns/1ps
module bus_irq_router
  import irqr_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] A_MASK  = 8'h30,
  parameter logic [ADDR_W-1:0] A_ROUTE = 8'h3D,
  parameter logic [ADDR_W-1:0] A_AUXEN = 8'h3E,
  parameter logic [ADDR_W-1:0] A_PEND  = 8'h32,
  parameter logic [ADDR_W-1:0] A_STAT  = 8'h34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS:1]   bus_irq_n,
  input  logic [AUX_N-1:0]  aux_req,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              irq_out,
  output logic              nmi_out
);
  logic [LEVELS:1]  lvl_req;
  logic [LEVELS:1]  lvl_sync;
  logic [AUX_N-1:0] aux_sync;
  logic [AUX_N-1:0] aux_flag;
  logic [AUX_N-1:0] aux_clr;
  ctrl_t            ctrl;

  // Named events for the assertions.
  logic lvl_hit;
  logic aux_any;
  logic aux_to_irq;

  assign lvl_req = ~bus_irq_n;

  irqr_sync #(.W(LEVELS)) i_lvl_sync (
    .clk(clk), .rst_n(rst_n), .d(lvl_req), .q(lvl_sync)
  );

  irqr_sync #(.W(AUX_N)) i_aux_sync (
    .clk(clk), .rst_n(rst_n), .d(aux_req), .q(aux_sync)
  );

  irqr_regs #(
    .ADDR_W(ADDR_W), .A_MASK(A_MASK), .A_ROUTE(A_ROUTE),
    .A_AUXEN(A_AUXEN), .A_PEND(A_PEND), .A_STAT(A_STAT)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .pend(lvl_sync),
    .flags(aux_flag), .ctrl(ctrl), .aux_clr(aux_clr)
  );

  irqr_aux_latch #(.N(AUX_N)) i_aux (
    .clk(clk), .rst_n(rst_n), .src(aux_sync), .en(ctrl.aux_en),
    .clr(aux_clr), .flag(aux_flag)
  );

  assign lvl_hit    = any_level(lvl_sync, ctrl.lvl_en, ctrl.gmask);
  assign aux_any    = |aux_flag;
  assign aux_to_irq = aux_any & ~ctrl.route_nmi;

  assign irq_out = lvl_hit | aux_to_irq;
  assign nmi_out = aux_any & ctrl.route_nmi;

  AST_NMI_AUX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_out |-> (aux_any && ctrl.route_nmi)); // R5
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.gmask && !aux_to_irq) |-> !irq_out); // R4
  AST_PEND_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == A_PEND) |-> (io_rdata[0] == 1'b0)); // R2
  AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_out && !lvl_hit) |-> !irq_out); // R8
endmodule

// File: tb/test_bus_irq_router.sv
`timescale 1ns/1ps
module test_bus_irq_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:1] bus_irq_n = 7'h7F;
  logic [2:0] aux_req = 3'b000;
  logic [7:0] io_addr = 8'h00;
  logic       io_wr = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic       irq_out, nmi_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_irq_router i_bus_irq_router (
    .clk(clk), .rst_n(rst_n), .bus_irq_n(bus_irq_n), .aux_req(aux_req),
    .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .irq_out(irq_out), .nmi_out(nmi_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    io_addr = a;
    #1;
    d = io_rdata;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  logic [7:0] elist [6] = '{8'hFE, 8'hAA, 8'h54, 8'h02, 8'h80, 8'h00};

  initial begin
    logic [7:0] v;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1: reset state
    rd(8'h30, v); chk("R1 mask reg", v, 8'h80);
    rd(8'h3D, v); chk("R1 route reg", v, 8'h00);
    rd(8'h3E, v); chk("R1 aux enable reg", v, 8'h00);
    rd(8'h32, v); chk("R1 pending", v, 8'h00);
    rd(8'h34, v); chk("R1 status", v, 8'h00);
    chk("R1 irq", {7'b0, irq_out}, 8'h00);
    chk("R1 nmi", {7'b0, nmi_out}, 8'h00);

    // R2 and R4: all levels enabled but globally masked
    wr(8'h3D, 8'hFE);
    for (int p = 0; p < 128; p++) begin
      bus_irq_n = ~p[6:0];
      tick(3);
      rd(8'h32, v); chk("R2 pending", v, {p[6:0], 1'b0});
      chk("R4 masked irq", {7'b0, irq_out}, 8'h00);
    end

    // R3 and R5: unmasked, sweep enable patterns and routing
    wr(8'h30, 8'h00);
    for (int e = 0; e < 6; e++) begin
      for (int r = 0; r < 2; r++) begin
        wr(8'h3D, {elist[e][7:1], r[0]});
        for (int p = 0; p < 128; p++) begin
          bus_irq_n = ~p[6:0];
          tick(3);
          chk("R3 irq", {7'b0, irq_out}, {7'b0, |({p[6:0], 1'b0} & elist[e])});
          chk("R5 nmi", {7'b0, nmi_out}, 8'h00);
        end
      end
    end
    bus_irq_n = 7'h7F;
    wr(8'h3D, 8'h00);
    tick(3);

    // R6, R7, R8, R9 per source and routing
    for (int s = 0; s < 3; s++) begin
      for (int r = 0; r < 2; r++) begin
        wr(8'h3D, {7'b0, r[0]});
        wr(8'h3E, 8'h07);
        aux_req[s] = 1'b1; tick(4);
        aux_req[s] = 1'b0; tick(4);
        rd(8'h34, v); chk("R6 sticky flag", v, 8'h01 << s);
        chk("R8 irq", {7'b0, irq_out}, {7'b0, ~r[0]});
        chk("R8 nmi", {7'b0, nmi_out}, {7'b0, r[0]});
        wr(8'h3E, 8'h07 & ~(8'h01 << s));
        rd(8'h34, v); chk("R7 cleared", v, 8'h00);
        chk("R7 irq low", {7'b0, irq_out | nmi_out}, 8'h00);
        aux_req[s] = 1'b1; tick(4);
        aux_req[s] = 1'b0; tick(4);
        rd(8'h34, v); chk("R7 ignored while disabled", v, 8'h00);
        aux_req[s] = 1'b1; tick(4);
        wr(8'h3E, 8'h07); tick(4);
        rd(8'h34, v); chk("R9 held source not captured", v, 8'h00);
        aux_req[s] = 1'b0; tick(4);
        aux_req[s] = 1'b1; tick(4);
        rd(8'h34, v); chk("R7 rearmed", v, 8'h01 << s);
        aux_req[s] = 1'b0;
        wr(8'h3E, 8'h00);
        tick(4);
      end
    end

    // R10: clear write on the capture edge
    wr(8'h3D, 8'h00);
    for (int s = 0; s < 3; s++) begin
      wr(8'h3E, 8'h07);
      tick(4);
      aux_req[s] = 1'b1;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      io_addr = 8'h3E; io_wdata = 8'h07 & ~(8'h01 << s); io_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      io_wr = 1'b0;
      rd(8'h34, v); chk("R10 clear wins", v, 8'h00);
      chk("R10 no output", {6'b0, irq_out, nmi_out}, 8'h00);
      aux_req[s] = 1'b0;
      tick(4);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule